// File: doc/BRIEF.md
# Dual Byte-Lane Column Strobe Controller

This block drives the two column strobes of a 16-bit asynchronous page-mode DRAM, one strobe per byte lane. A row controller signals that a page is open. A column command then arrives as a valid pulse with a two-bit byte-enable and a write flag. The block turns it into a timed column cycle. That cycle has an address/command setup interval, a strobe-low interval and a precharge interval. The block also produces the output-enable for reads and the write-data drive enable for writes.

The two lanes are never staggered. Every enabled lane falls on one clock edge and rises on one clock edge. Setup is therefore measured to the earliest fall, hold and precharge from the latest rise, and precharge only while both strobes are high. When a page mixes reads and writes, a direction change stretches the setup of the new cycle by two bus transition times. This keeps the output-enable released well before write data is driven. All intervals are clock-cycle parameters. The ready flag stays low until every interval of the current column cycle has expired.

Top module: `dual_lane_cas_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, both strobes and oe_n_o are high, wdrv_o is low and ready_o is high.
- R2: A command is taken only in a cycle where ready_o, cmd_valid_i and page_open_i are all high and cmd_be_i is not 00. Any other command presentation leaves every output unchanged.
- R3: Byte-enable bit 1 selects the upper strobe and bit 0 the lower strobe. All enabled strobes fall on the same edge and rise on the same edge. With 11 both lanes are strobed, giving a full 16-bit access.
- R4: The first cycle after the accepting edge is counted as cycle 1. The strobes stay high for S cycles, where S = T_ASC in a non-mixed cycle.
- R5: Strobes are low for exactly T_CAS cycles. They are then both high for T_CP cycles before ready_o rises. Precharge is counted only while both strobes are high.
- R6: On a read, oe_n_o is low during exactly the cycles the strobes are low. It is never pulsed shorter than that.
- R7: On a write, wdrv_o is high from cycle 1 through the last strobe-low cycle, and oe_n_o stays high. oe_n_o and wdrv_o are never active together.
- R8: If the previous command taken while the page stayed open had the other direction, S = T_ASC + 2*T_TT.
- R9: Any cycle with page_open_i low clears the direction history, so the next command is not treated as mixed.
- R10: ready_o is low for exactly S + T_CAS + T_CP cycles after acceptance and high in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| page_open_i | input | 1 | Row controller reports an open page |
| cmd_valid_i | input | 1 | Column command present |
| cmd_be_i | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| cmd_we_i | input | 1 | 1 = write, 0 = read |
| ucas_n_o | output | 1 | Upper-lane column strobe, active low |
| lcas_n_o | output | 1 | Lower-lane column strobe, active low |
| oe_n_o | output | 1 | Output enable, active low |
| wdrv_o | output | 1 | Write data drive enable |
| ready_o | output | 1 | Block can take a column command |

## Verification
The assertions assume the parameters are at least one cycle each. They also assume that a column cycle always starts from the idle phase, so the both-high precharge counter begins saturated at reset. The stimulus sweeps every ordered pair of the six legal commands after a page close. It presents a conflicting command during each busy cycle, and it offers a zero byte-enable and a closed-page command while idle. All changes are made at the falling clock edge, so no accepted command violates the setup assumptions.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_PRECH  = 2'd3
  } cas_phase_e;

  function automatic int unsigned cw_of(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction
endpackage

// File: rtl/cas_cycle_timer.sv
module cas_cycle_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R5: intervals run down one per cycle, never skip
  a_r5_timer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cas_lane_strobe.sv
module cas_lane_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic en_i,
  output logic strobe_n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_n_o <= 1'b1;
    else         strobe_n_o <= ~(act_i & en_i);
  end
endmodule

// File: rtl/dual_lane_cas_ctrl.sv
module dual_lane_cas_ctrl #(
  parameter int unsigned T_ASC = 2,
  parameter int unsigned T_CAS = 3,
  parameter int unsigned T_CP  = 2,
  parameter int unsigned T_TT  = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       page_open_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_be_i,
  input  logic       cmd_we_i,
  output logic       ucas_n_o,
  output logic       lcas_n_o,
  output logic       oe_n_o,
  output logic       wdrv_o,
  output logic       ready_o
);
  import cas_pkg::*;

  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned MAXV = T_ASC + 2*T_TT + T_CAS + T_CP;
  localparam int unsigned CW   = cw_of(MAXV);
  localparam int unsigned HW   = cw_of(T_CP);
  localparam int unsigned OW   = cw_of(T_CAS);

  cas_phase_e           phase_q, phase_d;
  logic [NUM_LANES-1:0] be_q, be_d;
  logic                 we_q, we_d;
  logic                 last_vld_q, last_we_q;
  logic                 accept, mix, t_load, t_done;
  logic [CW-1:0]        t_val;
  logic [NUM_LANES-1:0] strobe_n;

  assign accept = ready_o & cmd_valid_i & page_open_i & (|cmd_be_i);
  assign mix    = last_vld_q & (last_we_q != cmd_we_i);

  always_comb begin
    phase_d = phase_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        phase_d = PH_SETUP;
        t_load  = 1'b1;
        t_val   = mix ? CW'(T_ASC - 1 + 2*T_TT) : CW'(T_ASC - 1);
      end
      PH_SETUP: if (t_done) begin
        phase_d = PH_STROBE;
        t_load  = 1'b1;
        t_val   = CW'(T_CAS - 1);
      end
      PH_STROBE: if (t_done) begin
        phase_d = PH_PRECH;
        t_load  = 1'b1;
        t_val   = CW'(T_CP - 1);
      end
      PH_PRECH: if (t_done) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  assign be_d = accept ? cmd_be_i : be_q;
  assign we_d = accept ? cmd_we_i : we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      be_q       <= '0;
      we_q       <= 1'b0;
      last_vld_q <= 1'b0;
      last_we_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      be_q    <= be_d;
      we_q    <= we_d;
      if (!page_open_i) begin
        last_vld_q <= 1'b0;
      end else if (accept) begin
        last_vld_q <= 1'b1;
        last_we_q  <= cmd_we_i;
      end
    end
  end

  cas_cycle_timer #(.CW(CW)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (t_done)
  );

  // one strobe flop per lane, all driven from the same phase decode
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    cas_lane_strobe i_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (phase_d == PH_STROBE),
      .en_i       (be_d[g]),
      .strobe_n_o (strobe_n[g])
    );
  end

  assign ucas_n_o = strobe_n[1];
  assign lcas_n_o = strobe_n[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_n_o  <= 1'b1;
      wdrv_o  <= 1'b0;
      ready_o <= 1'b1;
    end else begin
      oe_n_o  <= ~((phase_d == PH_STROBE) & ~we_d);
      wdrv_o  <= we_d & ((phase_d == PH_SETUP) | (phase_d == PH_STROBE));
      ready_o <= (phase_d == PH_IDLE);
    end
  end

  // both-high precharge and OE width trackers for the checks below
  logic [HW-1:0] hi_cnt_q;
  logic [OW-1:0] oe_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= HW'(T_CP);
      oe_cnt_q <= '0;
    end else begin
      if (!(ucas_n_o & lcas_n_o))   hi_cnt_q <= '0;
      else if (hi_cnt_q < HW'(T_CP)) hi_cnt_q <= hi_cnt_q + 1'b1;
      if (oe_n_o)                    oe_cnt_q <= '0;
      else if (oe_cnt_q < OW'(T_CAS)) oe_cnt_q <= oe_cnt_q + 1'b1;
    end
  end

  // R3: a falling edge on either lane brings down every enabled lane together
  a_r3_no_stagger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ucas_n_o) || $fell(lcas_n_o)) |-> ({ucas_n_o, lcas_n_o} == ~be_q));

  // R5: precharge is satisfied, counted on both-high cycles only
  a_r5_both_high_prech: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ucas_n_o) || $fell(lcas_n_o)) |-> (hi_cnt_q == HW'(T_CP)));

  // R6: OE released only after a full strobe width
  a_r6_oe_full_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_n_o) |-> (oe_cnt_q == OW'(T_CAS)));

  // R7: never drive write data while outputs are enabled
  a_r7_oe_wdrv_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_n_o && wdrv_o));

  // R10: idle means quiet bus
  a_r10_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ucas_n_o && lcas_n_o && oe_n_o && !wdrv_o));
endmodule

// File: tb/test_dual_lane_cas_ctrl.sv
module test_dual_lane_cas_ctrl;
  localparam int T_CLK = 10;
  localparam int T_ASC = 2;
  localparam int T_CAS = 3;
  localparam int T_CP  = 2;
  localparam int T_TT  = 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic page_open_i = 1'b0, cmd_valid_i = 1'b0, cmd_we_i = 1'b0;
  logic [1:0] cmd_be_i = 2'b00;
  logic ucas_n_o, lcas_n_o, oe_n_o, wdrv_o, ready_o;
  int n_run = 0, n_fail = 0;
  logic h_vld = 1'b0, h_we = 1'b0;

  always #(T_CLK/2) clk = ~clk;

  dual_lane_cas_ctrl #(.T_ASC(T_ASC), .T_CAS(T_CAS), .T_CP(T_CP), .T_TT(T_TT))
    i_dual_lane_cas_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .page_open_i(page_open_i),
    .cmd_valid_i(cmd_valid_i), .cmd_be_i(cmd_be_i), .cmd_we_i(cmd_we_i),
    .ucas_n_o(ucas_n_o), .lcas_n_o(lcas_n_o), .oe_n_o(oe_n_o),
    .wdrv_o(wdrv_o), .ready_o(ready_o));

  // vector order: ucas_n, lcas_n, oe_n, wdrv, ready
  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {ucas_n_o, lcas_n_o, oe_n_o, wdrv_o, ready_o};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  localparam logic [4:0] IDLE_V = 5'b11101;

  // R9: closing the page for one cycle clears direction history
  task automatic close_page();
    page_open_i = 1'b0;
    @(negedge clk);
    h_vld = 1'b0;
    page_open_i = 1'b1;
  endtask

  task automatic run_cmd(input logic [1:0] be, input logic we);
    int s, len;
    logic [4:0] e;
    s = T_ASC + ((h_vld && h_we != we) ? 2*T_TT : 0);   // R8
    len = s + T_CAS + T_CP;
    cmd_valid_i = 1'b1; cmd_be_i = be; cmd_we_i = we;
    @(negedge clk);
    h_vld = 1'b1; h_we = we;
    // R2: conflicting command while busy must be ignored
    cmd_be_i = ~be | 2'b01; cmd_we_i = ~we;
    for (int i = 1; i <= len; i++) begin
      if (i <= s) begin
        e = {1'b1, 1'b1, 1'b1, we, 1'b0};
        chk(h_vld && s > T_ASC ? "R8 setup" : "R4 setup", e);
      end else if (i <= s + T_CAS) begin
        e = {~be[1], ~be[0], we, we, 1'b0};
        chk(we ? "R3/R7 strobe" : "R3/R6 strobe", e);
      end else begin
        chk("R5 precharge", 5'b11100);
      end
      if (i == len) cmd_valid_i = 1'b0;
      @(negedge clk);
    end
    chk("R10 ready back", IDLE_V);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 in reset", IDLE_V);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset", IDLE_V);

    // R2: zero byte enable ignored
    page_open_i = 1'b1;
    cmd_valid_i = 1'b1; cmd_be_i = 2'b00; cmd_we_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R2 be zero", IDLE_V);
    end
    // R2: closed page ignored
    page_open_i = 1'b0; cmd_be_i = 2'b11;
    repeat (3) begin
      @(negedge clk);
      chk("R2 page closed", IDLE_V);
    end
    cmd_valid_i = 1'b0;
    page_open_i = 1'b1;
    @(negedge clk);

    // R9: read, close, write -> write not mixed
    run_cmd(2'b11, 1'b0);
    close_page();
    run_cmd(2'b11, 1'b1);

    // all ordered pairs of the six legal commands
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        close_page();
        run_cmd(2'(a % 3 + 1), a >= 3);
        run_cmd(2'(b % 3 + 1), b >= 3);
      end
    end
    // long mixed page: r w r w
    close_page();
    for (int k = 0; k < 4; k++) run_cmd(2'b11, k[0]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule